// File: doc/BRIEF.md
# Three-Level Phase-Disposition PWM Modulator

This block turns three signed phase references into the twelve gate signals of a three-leg, three-level neutral-point-clamped inverter. Each leg owns four series switches. A single up/down counter produces a triangular carrier. Two level-shifted, in-phase carriers are derived from it. The upper carrier spans 0 to +1 and the lower carrier spans -1 to 0. Every clock, each leg compares its reference against both carriers. The result picks one of three leg levels: positive half rail, zero (clamped to the midpoint), or negative half rail.

The references are sampled once per switching period, at the carrier valley, which gives regular symmetric sampling. A one-cycle period-start strobe tells the control loop when that sample was taken. Each complementary switch pair has a dead-time stage. A switch turns on only after its partner has been off for the dead time. Once on, a switch stays on for at least that same time before it may turn off. While enable is low, every gate is off and the carrier waits at its valley.

References use carrier units: a value of `HALF_CNT` means +1 and `-HALF_CNT` means -1. With the default 250 MHz clock, `HALF_CNT` = 67500 gives a 540 µs switching period and `DEAD_CNT` = 5625 gives 22.5 µs of dead time.

Top module: `npc_pdpwm_mod`

## Requirements
- R1: While enabled, the carrier counts 0,1,…,HALF_CNT,…,1 with a period of 2·HALF_CNT clocks. `period_start_o` is high for exactly one cycle per period. That cycle follows the clock edge at which the carrier sat at its valley (count 0), and the first one follows the first edge with `en_i` high.
- R2: A leg's reference is sampled only at the valley edge. Changes between valleys have no effect on the gates until the next valley.
- R3: If the sampled reference is greater than the upper carrier (the count), the leg targets the positive level. This is S1 and S2 on, gate bits 4p+0 and 4p+1 for phase p.
- R4: If the reference is not above the upper carrier but is greater than the lower carrier (count − HALF_CNT), the leg targets zero. This is S2 and S3 on, bits 4p+1 and 4p+2.
- R5: Otherwise the leg targets the negative level. This is S3 and S4 on, bits 4p+2 and 4p+3.
- R6: The S1/S3 pair and the S2/S4 pair are never both on. At most two switches of a leg conduct at once.
- R7: A switch turns on only after its complementary partner has been off for at least DEAD_CNT cycles. When a change is allowed, the conducting switch turns off with no added delay.
- R8: While enabled, a switch that turned on stays on for at least DEAD_CNT cycles.
- R9: With `en_i` low, all gates and the strobe are 0 from the next cycle on. When `en_i` rises again, the carrier restarts at its valley.
- R10: During and right after reset, all gates and the strobe are 0.
- R11: A reference held between 0 and HALF_CNT/2 (modulation index below 0.5) produces only the positive and zero levels. S4 never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces all gates off |
| ref_i | input | PHASES·REF_W | Signed phase references, phase p at bits p·REF_W upward |
| gate_o | output | 4·PHASES | Gate drives, bit 4p+s is switch S(s+1) of phase p, S1 nearest the positive rail |
| period_start_o | output | 1 | One-cycle strobe each switching period |

## Verification
The carrier counter, the latched references and the per-pair dead-time state are hidden. Each of them reaches the gates within a few cycles. A carrier slip moves the strobe off its 2·HALF_CNT spacing at the next valley. A badly latched reference changes the leg level within one period, so the gate pattern differs from one computed independently in the next cycles. A dead-time counter that is off by one shows up at the first transition of that pair. There, either the partner's off interval or the on-pulse width falls below DEAD_CNT, or the turn-on lands a cycle early or late.

// File: rtl/npc_pwm_pkg.sv
package npc_pwm_pkg;

  typedef enum logic [1:0] {
    LVL_NEG  = 2'd0,
    LVL_ZERO = 2'd1,
    LVL_POS  = 2'd2
  } lvl_e;

  // outer pair (S1 vs S3): S1 side wanted only at the positive level
  function automatic logic outer_hi(lvl_e l);
    return (l == LVL_POS);
  endfunction

  // inner pair (S2 vs S4): S2 side wanted unless at the negative level
  function automatic logic inner_hi(lvl_e l);
    return (l != LVL_NEG);
  endfunction

endpackage

// File: rtl/npc_tri_carrier.sv
module npc_tri_carrier #(
  parameter int HALF_CNT = 67500,
  parameter int CNTW     = $clog2(HALF_CNT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  output logic [CNTW-1:0] cnt_o,
  output logic            valley_o
);

  logic            rising;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt == CNTW'(HALF_CNT - 1)) begin
        cnt    <= CNTW'(HALF_CNT);
        rising <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == CNTW'(1)) begin
        cnt    <= '0;
        rising <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt;
  assign valley_o = (cnt == '0);

endmodule

// File: rtl/npc_leg_cmp.sv
module npc_leg_cmp
  import npc_pwm_pkg::*;
#(
  parameter int HALF_CNT = 67500,
  parameter int REF_W    = 18,
  parameter int CNTW     = $clog2(HALF_CNT + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    valley_i,
  input  logic [CNTW-1:0]         cnt_i,
  input  logic signed [REF_W-1:0] ref_i,
  output lvl_e                    lvl_o
);

  localparam int CW = REF_W + 2;

  logic signed [REF_W-1:0] ref_q;
  logic signed [REF_W-1:0] ref_eff;
  logic signed [CW-1:0]    r_s;
  logic signed [CW-1:0]    up_s;
  logic signed [CW-1:0]    lo_s;
  lvl_e                    lvl_d;

  // the valley sample applies from the valley itself
  assign ref_eff = valley_i ? ref_i : ref_q;

  always_comb begin
    r_s  = CW'(ref_eff);
    up_s = CW'(cnt_i);
    lo_s = up_s - CW'(HALF_CNT);
    if (r_s > up_s)      lvl_d = LVL_POS;
    else if (r_s > lo_s) lvl_d = LVL_ZERO;
    else                 lvl_d = LVL_NEG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      lvl_o <= LVL_ZERO;
    end else if (!en_i) begin
      lvl_o <= LVL_ZERO;
    end else begin
      if (valley_i) ref_q <= ref_i;
      lvl_o <= lvl_d;
    end
  end

endmodule

// File: rtl/npc_pair_dt.sv
module npc_pair_dt #(
  parameter int DEAD_CNT = 5625,
  parameter int DW       = $clog2(DEAD_CNT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic want_hi_i,
  output logic hi_o,
  output logic lo_o
);

  localparam logic [DW-1:0] DEAD = DW'(DEAD_CNT);

  logic          side;   // 1: high switch is the target
  logic [DW-1:0] run;    // cycles spent in the present phase

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
      side <= 1'b0;
      run  <= '0;
    end else if (!en_i) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
      side <= want_hi_i;
      run  <= '0;
    end else if (!(hi_o || lo_o)) begin
      // both off: wait out the dead time before turning the target on
      if (want_hi_i != side) begin
        side <= want_hi_i;
        run  <= DW'(1);
      end else if (run < DEAD) begin
        run <= run + 1'b1;
      end else begin
        hi_o <= side;
        lo_o <= ~side;
        run  <= DW'(1);
      end
    end else begin
      // one switch on: hold for the minimum width, then follow the target
      if ((want_hi_i != side) && (run >= DEAD)) begin
        hi_o <= 1'b0;
        lo_o <= 1'b0;
        side <= want_hi_i;
        run  <= DW'(1);
      end else if (run < DEAD) begin
        run <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/npc_pdpwm_mod.sv
module npc_pdpwm_mod
  import npc_pwm_pkg::*;
#(
  parameter int PHASES   = 3,
  parameter int HALF_CNT = 67500,
  parameter int DEAD_CNT = 5625,
  parameter int REF_W    = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic [PHASES*REF_W-1:0]   ref_i,
  output logic [4*PHASES-1:0]       gate_o,
  output logic                      period_start_o
);

  localparam int CNTW = $clog2(HALF_CNT + 1);

  logic [CNTW-1:0] car_cnt;
  logic            car_valley;

  npc_tri_carrier #(.HALF_CNT(HALF_CNT), .CNTW(CNTW)) carrier_i (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .cnt_o    (car_cnt),
    .valley_o (car_valley)
  );

  always_ff @(posedge clk) begin
    if (rst) period_start_o <= 1'b0;
    else     period_start_o <= en_i && car_valley;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    lvl_e lvl;

    npc_leg_cmp #(.HALF_CNT(HALF_CNT), .REF_W(REF_W), .CNTW(CNTW)) cmp_i (
      .clk      (clk),
      .rst      (rst),
      .en_i     (en_i),
      .valley_i (car_valley),
      .cnt_i    (car_cnt),
      .ref_i    (ref_i[p*REF_W +: REF_W]),
      .lvl_o    (lvl)
    );

    npc_pair_dt #(.DEAD_CNT(DEAD_CNT)) outer_i (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_i),
      .want_hi_i (outer_hi(lvl)),
      .hi_o      (gate_o[4*p+0]),
      .lo_o      (gate_o[4*p+2])
    );

    npc_pair_dt #(.DEAD_CNT(DEAD_CNT)) inner_i (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_i),
      .want_hi_i (inner_hi(lvl)),
      .hi_o      (gate_o[4*p+1]),
      .lo_o      (gate_o[4*p+3])
    );
  end

endmodule

// File: rtl/npc_pdpwm_chk.sv
module npc_pdpwm_chk #(
  parameter int PHASES   = 3,
  parameter int DEAD_CNT = 5625
) (
  input logic                clk,
  input logic                rst,
  input logic                en_i,
  input logic [4*PHASES-1:0] gate_o,
  input logic                period_start_o
);

  localparam int NSW = 4 * PHASES;
  localparam int DW  = $clog2(DEAD_CNT + 1);
  localparam logic [DW-1:0] DEAD = DW'(DEAD_CNT);

  logic [DW-1:0] off_run [NSW];
  logic [DW-1:0] on_run  [NSW];

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    always_ff @(posedge clk) begin
      if (rst) begin
        off_run[i] <= '0;
        on_run[i]  <= '0;
      end else begin
        off_run[i] <= gate_o[i] ? '0 : ((off_run[i] < DEAD) ? off_run[i] + 1'b1 : off_run[i]);
        on_run[i]  <= !gate_o[i] ? '0 : ((on_run[i] < DEAD) ? on_run[i] + 1'b1 : on_run[i]);
      end
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_o[i]) |-> (off_run[i ^ 2] >= DEAD)); // R7

    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (rst)
      ($fell(gate_o[i]) && $past(en_i)) |-> (on_run[i] >= DEAD)); // R8
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
      !(gate_o[4*p] && gate_o[4*p+2]) && !(gate_o[4*p+1] && gate_o[4*p+3])); // R6

    AST_LEG_TWO: assert property (@(posedge clk) disable iff (rst)
      $countones(gate_o[4*p +: 4]) <= 2); // R6
  end

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (gate_o == '0) && !period_start_o); // R9

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_start_o |=> !period_start_o); // R1

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (gate_o == '0) && !period_start_o); // R10

endmodule

bind npc_pdpwm_mod npc_pdpwm_chk #(.PHASES(PHASES), .DEAD_CNT(DEAD_CNT)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .en_i           (en_i),
  .gate_o         (gate_o),
  .period_start_o (period_start_o)
);

// File: tb/npc_pdpwm_mod_tb.sv
module npc_pdpwm_mod_tb_top;

  localparam int P  = 3;
  localparam int H  = 16;
  localparam int D  = 3;
  localparam int RW = 8;
  localparam int NS = 4 * P;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            en  = 1'b0;
  logic [P*RW-1:0] ref_v = '0;
  logic [NS-1:0]   gate;
  logic            stb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  npc_pdpwm_mod #(.PHASES(P), .HALF_CNT(H), .DEAD_CNT(D), .REF_W(RW)) dut_i (
    .clk            (clk),
    .rst            (rst),
    .en_i           (en),
    .ref_i          (ref_v),
    .gate_o         (gate),
    .period_start_o (stb)
  );

  // ---------------- expected-value model from the requirements ----------
  int mk;
  int mref [P];
  int mlvl [P];      // 0 neg, 1 zero, 2 pos
  bit mcur [2*P];
  bit mhi  [2*P];
  bit mlo  [2*P];
  int mcnt [2*P];
  bit mstb;
  bit men_edge;

  function automatic int tri_val(int k);
    return (k <= H) ? k : 2*H - k;
  endfunction

  function automatic int lvl_f(int r, int c);
    if (r > c) return 2;
    if (r > c - H) return 1;
    return 0;
  endfunction

  function automatic bit want_f(int lvl, int s);
    return (s == 0) ? (lvl == 2) : (lvl != 0);
  endfunction

  function automatic int ref_at(int p);
    return int'($signed(ref_v[p*RW +: RW]));
  endfunction

  always @(posedge clk) begin
    men_edge = en;
    if (rst) begin
      mk = 0; mstb = 0;
      for (int p = 0; p < P; p++) begin mref[p] = 0; mlvl[p] = 1; end
      for (int q = 0; q < 2*P; q++) begin mcur[q] = 0; mhi[q] = 0; mlo[q] = 0; mcnt[q] = 0; end
    end else if (!en) begin
      mk = 0; mstb = 0;
      for (int q = 0; q < 2*P; q++) begin
        mcur[q] = want_f(mlvl[q/2], q%2); mhi[q] = 0; mlo[q] = 0; mcnt[q] = 0;
      end
      for (int p = 0; p < P; p++) mlvl[p] = 1;
    end else begin
      int c;
      bit v;
      c = tri_val(mk);
      v = (c == 0);
      for (int q = 0; q < 2*P; q++) begin
        bit w;
        w = want_f(mlvl[q/2], q%2);
        if (!(mhi[q] || mlo[q])) begin
          if (w != mcur[q]) begin mcur[q] = w; mcnt[q] = 1; end
          else if (mcnt[q] < D) mcnt[q]++;
          else begin mhi[q] = mcur[q]; mlo[q] = !mcur[q]; mcnt[q] = 1; end
        end else begin
          if (w != mcur[q] && mcnt[q] >= D) begin mhi[q] = 0; mlo[q] = 0; mcur[q] = w; mcnt[q] = 1; end
          else if (mcnt[q] < D) mcnt[q]++;
        end
      end
      for (int p = 0; p < P; p++) begin
        int r;
        r = v ? ref_at(p) : mref[p];
        if (v) mref[p] = ref_at(p);
        mlvl[p] = lvl_f(r, c);
      end
      mstb = v;
      mk = (mk + 1) % (2*H);
    end
  end

  function automatic logic [NS-1:0] exp_gate();
    logic [NS-1:0] g;
    for (int p = 0; p < P; p++) begin
      g[4*p+0] = mhi[2*p];
      g[4*p+1] = mhi[2*p+1];
      g[4*p+2] = mlo[2*p];
      g[4*p+3] = mlo[2*p+1];
    end
    return g;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- per-cycle monitor ----------------
  logic [NS-1:0] g_prev = '0;
  int b_off [NS];
  int b_on  [NS];
  int s4_seen = 0;
  int s1_seen = 0;

  initial for (int i = 0; i < NS; i++) begin b_off[i] = 0; b_on[i] = 0; end

  always @(negedge clk) begin
    if (mon_on) begin
      chk("R1 strobe", int'(stb), int'(mstb));
      chk("R3 R4 R5 R7 gates", int'(gate), int'(exp_gate()));
      for (int p = 0; p < P; p++) begin
        chk("R6 pair overlap", int'((gate[4*p] && gate[4*p+2]) || (gate[4*p+1] && gate[4*p+3])), 0);
        if (gate[4*p+3]) s4_seen++;
        if (gate[4*p+0]) s1_seen++;
      end
      for (int i = 0; i < NS; i++) begin
        if (gate[i] && !g_prev[i]) chk("R7 partner off time", int'(b_off[i ^ 2] >= D), 1);
        if (!gate[i] && g_prev[i] && men_edge) chk("R8 min pulse", int'(b_on[i] >= D), 1);
      end
    end
    for (int i = 0; i < NS; i++) begin
      b_off[i] = gate[i] ? 0 : b_off[i] + 1;
      b_on[i]  = gate[i] ? b_on[i] + 1 : 0;
    end
    g_prev = gate;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!stb);
  endtask

  task automatic set_ref(int p, int v);
    ref_v[p*RW +: RW] = RW'(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    tick(3);
    chk("R10 gates in reset", int'(gate), 0);
    chk("R10 strobe in reset", int'(stb), 0);
    rst = 1'b0;
    tick(1);
    chk("R10 gates after reset", int'(gate), 0);
    mon_on = 1'b1;

    // first strobe right after enable, then spacing
    en = 1'b1;
    tick(1);
    chk("R1 R9 first strobe", int'(stb), 1);
    n = 0;
    do begin tick(1); n++; end while (!stb);
    chk("R1 period", n, 2*H);

    // positive level, then a mid-period change that must wait
    set_ref(0, 20);
    wait_strobe();
    tick(12);
    chk("R3 positive pattern", int'(gate[3:0]), 4'b0011);
    set_ref(0, -20);
    tick(8);
    chk("R2 no change before valley", int'(gate[3:0]), 4'b0011);
    wait_strobe();
    tick(12);
    chk("R5 negative pattern", int'(gate[3:0]), 4'b1100);

    // zero level mid period
    set_ref(0, 4);
    wait_strobe();
    wait_strobe();
    tick(14);
    chk("R4 zero pattern", int'(gate[3:0]), 4'b0110);

    // modulation index below one half
    for (int p = 0; p < P; p++) set_ref(p, 1 + int'($urandom_range(6)));
    wait_strobe();
    s4_seen = 0; s1_seen = 0;
    tick(4 * 2 * H);
    chk("R11 no S4 below half index", s4_seen, 0);
    chk("R11 positive level present", int'(s1_seen > 0), 1);

    // disable mid period
    tick(5);
    en = 1'b0;
    tick(1);
    chk("R9 gates off", int'(gate), 0);
    chk("R9 strobe off", int'(stb), 0);
    tick(4);
    en = 1'b1;
    tick(1);
    chk("R9 restart at valley", int'(stb), 1);

    // constrained random run
    for (int it = 0; it < 200; it++) begin
      for (int p = 0; p < P; p++) set_ref(p, int'($urandom_range(40)) - 20);
      if ($urandom_range(15) == 0) begin
        en = 1'b0;
        tick(1 + int'($urandom_range(4)));
        en = 1'b1;
      end
      tick(1 + int'($urandom_range(39)));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule